// File: doc/BRIEF.md
# Infrared-Mode Serial Receiver

This block receives asynchronous serial characters on a single raw line. It divides the bus clock by a programmable divisor to get a receive-time tick, so that sixteen ticks make one bit period. The raw line first passes through a two-stage synchronizer, and all decoding works from the synchronized copy. In normal mode each bit is judged by a majority vote of three mid-bit samples. In infrared mode a zero bit arrives as a short low pulse near the start of its bit period, and a one bit arrives as no pulse at all.

A sticky edge flag records every falling edge of the synchronized line, whatever the receiver is doing. Software clears it by pulsing a clear input. When the stop bit has been judged, the block presents the received byte together with a one-cycle valid strobe and per-byte noise and framing indications.

The control is a four-state machine. IDLE waits for a tick that sees the line low (transition start_seen, to START). START judges the start bit at tick 10: a high vote in normal mode returns to IDLE (false_start), and otherwise the machine moves to DATA (start_ok). DATA stays in DATA across bit decisions (next_bit) and moves to STOP after the last data bit (last_bit). STOP judges the stop bit, issues the strobe and returns to IDLE (frame_done).

Top module: `ir_serial_rx`

## Requirements
- R1: While reset is asserted and right after it is released, rx_data is 0 and rx_valid, noise_err, frame_err and edge_flag are all 0.
- R2: One receive tick occurs every baud_div bus cycles, and a divisor of 0 behaves like a divisor of 1. Frames sent with 16·baud_div bus cycles per bit are received correctly at every divisor.
- R3: In normal mode a frame is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit. Each bit takes the majority of the synchronized line sampled at ticks 8, 9 and 10 of that bit, counting the start-detecting tick as tick 1. The assembled byte appears on rx_data.
- R4: rx_valid is high for exactly one bus cycle per received frame. rx_data, noise_err and frame_err change only in that cycle and hold their values until the next strobe.
- R5: In normal mode noise_err is 1 with a byte's strobe if the three samples of any of its bits disagreed, and 0 if all of them agreed.
- R6: frame_err is 1 with a byte's strobe when its stop bit decodes as 0. The byte is still delivered.
- R7: In normal mode, a start whose three votes give 1 is discarded without a strobe, and a low glitch shorter than a bit produces no byte.
- R8: When ir_mode is 1, a bit decodes as 0 if the synchronized line was low in any bus cycle of its window, and as 1 otherwise. The window runs from the previous bit's tick-10 decision up to its own tick 10. The start bit is the first pulse, and noise_err stays 0.
- R9: edge_flag becomes 1 on every falling edge of the synchronized line, in any state and either mode, including each pulse of consecutive infrared zeros. It is set two clock edges after the edge that first samples the low raw level.
- R10: Pulsing edge_clr high clears edge_flag. If a falling edge arrives in the same cycle as edge_clr, the flag is set.
- R11: If any bit boundary arrives one bus cycle late, or a detected edge arrives one tick late, the received data is unchanged.
- R12: After its tick-10 stop decision the receiver is idle again, so a frame that starts right after the previous stop bit ends is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Bus cycles per receive tick (0 acts as 1) |
| ir_mode | input | 1 | 1 selects infrared pulse decoding |
| rxd_raw | input | 1 | Unsynchronized serial input, idle high |
| edge_clr | input | 1 | Write-1 clear for edge_flag |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe per received byte |
| noise_err | output | 1 | Vote disagreement seen in last byte |
| frame_err | output | 1 | Stop bit of last byte decoded as 0 |
| edge_flag | output | 1 | Sticky falling-edge flag |

## Verification
The edge detector and the software clear can act in the same cycle. The bench drives a one-cycle low glitch, times edge_clr so that it is sampled on exactly the edge where the synchronized fall is registered, and expects the flag to read 1 afterwards. A lone clear one cycle later must bring it back to 0. The stop decision and a new start can also fall close together: back-to-back frames with no idle gap, and frames whose stop bit is low, check that the strobe, the return to IDLE and the next start detection do not disturb one another.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    // Ticks per bit and the positions of the three voting samples.
    localparam int OSR      = 16;
    localparam int RT_W     = $clog2(OSR) + 1;
    localparam int SAMPLE_A = 8;
    localparam int SAMPLE_B = 9;
    localparam int SAMPLE_C = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/ir_rx_sync.sv
module ir_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = last & ~chain[STAGES-1];

endmodule

// File: rtl/ir_rx_baud.sv
module ir_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // A divisor of zero is treated like one.
    assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/ir_rx_edge.sv
module ir_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic clr,
    output logic flag
);
    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (fall) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ir_rx_fsm.sv
module ir_rx_fsm
    import ir_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              ir_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              noise_err,
    output logic              frame_err,
    output rx_state_e         state
);
    localparam int              BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [RT_W-1:0]  RT_ONE   = RT_W'(1);
    localparam logic [RT_W-1:0]  RT_TOP   = RT_W'(OSR);
    localparam logic [RT_W-1:0]  RT_S_A   = RT_W'(SAMPLE_A);
    localparam logic [RT_W-1:0]  RT_S_B   = RT_W'(SAMPLE_B);
    localparam logic [RT_W-1:0]  RT_DEC   = RT_W'(SAMPLE_C);

    rx_state_e         state_q, state_d;
    logic [RT_W-1:0]   rt_q;      // index of the last tick taken in this bit
    logic [RT_W-1:0]   rt_cur;    // index of the tick being taken now
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              samp_a_q, samp_b_q;
    logic              low_q;     // infrared window saw a low level
    logic              noise_q;
    logic              busy, at_dec, start_go, frame_end;
    logic              bit_val, disagree;

    assign busy      = (state_q != ST_IDLE);
    assign rt_cur    = (rt_q == RT_TOP) ? RT_ONE : rt_q + RT_ONE;
    assign at_dec    = tick && busy && (rt_cur == RT_DEC);
    assign start_go  = (state_q == ST_IDLE) && tick && !rx_s;
    assign frame_end = (state_q == ST_STOP) && at_dec;

    // Bit value at the decision tick; in infrared mode any low level in
    // the window (including the current cycle) means zero.
    assign bit_val  = ir_mode ? (!low_q && rx_s) : vote3(samp_a_q, samp_b_q, rx_s);
    assign disagree = !ir_mode && !((samp_a_q == samp_b_q) && (samp_b_q == rx_s));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_go) state_d = ST_START;             // start_seen
            end
            ST_START: begin
                if (at_dec) begin
                    if (!ir_mode && bit_val) state_d = ST_IDLE; // false_start
                    else                     state_d = ST_DATA; // start_ok
                end
            end
            ST_DATA: begin
                if (at_dec && (bit_q == LAST_BIT)) state_d = ST_STOP; // last_bit
            end
            ST_STOP: begin
                if (at_dec) state_d = ST_IDLE;                // frame_done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and bit-timing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rt_q     <= RT_ONE;
            bit_q    <= '0;
            shift_q  <= '0;
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
            low_q    <= 1'b0;
            noise_q  <= 1'b0;
        end else begin
            state_q <= state_d;

            if (start_go) begin
                rt_q <= RT_ONE;
            end else if (tick && busy) begin
                rt_q <= rt_cur;
            end

            if (tick && busy && (rt_cur == RT_S_A)) samp_a_q <= rx_s;
            if (tick && busy && (rt_cur == RT_S_B)) samp_b_q <= rx_s;

            if (!busy || at_dec) begin
                low_q <= 1'b0;
            end else if (!rx_s) begin
                low_q <= 1'b1;
            end

            if (start_go) begin
                noise_q <= 1'b0;
            end else if (at_dec) begin
                noise_q <= noise_q | disagree;
            end

            if (start_go) begin
                bit_q <= '0;
            end else if (at_dec && (state_q == ST_DATA)) begin
                shift_q <= {bit_val, shift_q[DATA_W-1:1]};
                bit_q   <= bit_q + BIT_W'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            noise_err <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid <= frame_end;
            if (frame_end) begin
                rx_data   <= shift_q;
                noise_err <= noise_q | disagree;
                frame_err <= !bit_val;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/ir_serial_rx.sv
module ir_serial_rx
    import ir_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              ir_mode,
    input  logic              rxd_raw,
    input  logic              edge_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              noise_err,
    output logic              frame_err,
    output logic              edge_flag
);
    logic      rx_s;
    logic      fall_w;
    logic      tick_w;
    rx_state_e state_w;

    ir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_raw),
        .dout (rx_s),
        .fall (fall_w)
    );

    ir_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (tick_w)
    );

    ir_rx_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .fall (fall_w),
        .clr  (edge_clr),
        .flag (edge_flag)
    );

    ir_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .rx_s     (rx_s),
        .ir_mode  (ir_mode),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .noise_err(noise_err),
        .frame_err(frame_err),
        .state    (state_w)
    );

endmodule

// File: rtl/ir_serial_rx_chk.sv
module ir_serial_rx_chk
    import ir_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              fall,
    input logic              edge_clr,
    input logic              edge_flag,
    input logic              rx_valid,
    input logic              noise_err,
    input logic              frame_err,
    input logic [DATA_W-1:0] rx_data,
    input logic [DIV_W-1:0]  baud_div,
    input rx_state_e         state
);

    // R2: with a steady divisor above one, ticks never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (baud_div > DIV_W'(1))) |=> (!tick || (baud_div != $past(baud_div))));

    // R4: the strobe lasts a single cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: byte and status hold between strobes
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(noise_err) && $stable(frame_err)));

    // R9: a synchronized falling edge always sets the flag
    a_r9_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> edge_flag);

    // R10: a clear without a competing edge empties the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_clr && !fall) |=> !edge_flag);

    // R12: the receiver is already idle while the strobe is shown
    a_r12_idle_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state == ST_IDLE));

endmodule

bind ir_serial_rx ir_serial_rx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .fall     (fall_w),
    .edge_clr (edge_clr),
    .edge_flag(edge_flag),
    .rx_valid (rx_valid),
    .noise_err(noise_err),
    .frame_err(frame_err),
    .rx_data  (rx_data),
    .baud_div (baud_div),
    .state    (state_w)
);

// File: tb/ir_serial_rx_tb_top.sv
module ir_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic        ir_mode = 1'b0;
    logic        rxd_raw = 1'b1;
    logic        edge_clr = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        noise_err;
    logic        frame_err;
    logic        edge_flag;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [7:0] cap_data = '0;
    logic       cap_noise = 1'b0;
    logic       cap_frame = 1'b0;

    always #10 clk = ~clk;

    ir_serial_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_div (baud_div),
        .ir_mode  (ir_mode),
        .rxd_raw  (rxd_raw),
        .edge_clr (edge_clr),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .noise_err(noise_err),
        .frame_err(frame_err),
        .edge_flag(edge_flag)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount    = vcount + 1;
            cap_data  = rx_data;
            cap_noise = noise_err;
            cap_frame = frame_err;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one frame. jit: 0/1 fixed boundary delay in cycles, 2 random.
    // glitch_j: bit index whose cycle 8 is inverted (normal mode), -1 none.
    task automatic send_frame(input logic [7:0] b, input int d, input logic ir,
                              input logic stop_v, input int glitch_j, input int jit,
                              input logic echk);
        int   dm;
        int   blen;
        logic prev;
        dm   = (d == 0) ? 1 : d;
        blen = 16 * dm;
        prev = 1'b1;
        baud_div = d[15:0];
        ir_mode  = ir;
        for (int j = 0; j < 10; j++) begin
            logic lv;
            int   e;
            lv = (j == 0) ? 1'b0 : ((j == 9) ? stop_v : b[j-1]);
            e  = (jit == 2) ? int'($urandom_range(1, 0)) : jit;
            for (int c = 0; c < blen; c++) begin
                logic r;
                @(negedge clk);
                if (ir) begin
                    r = !((lv == 1'b0) && (c >= e) && (c < e + 3 * dm));
                end else begin
                    r = (c < e) ? prev : lv;
                    if ((j == glitch_j) && (c == 8)) r = ~lv;
                end
                rxd_raw = r;
                if (echk && ir && (c == blen - 2)) begin
                    chk("R9 edge flag per infrared pulse", edge_flag, (lv == 1'b0));
                    edge_clr = 1'b1;
                end else begin
                    edge_clr = 1'b0;
                end
            end
            prev = ir ? 1'b1 : lv;
        end
        @(negedge clk);
        rxd_raw  = 1'b1;
        edge_clr = 1'b0;
    endtask

    task automatic run_frame(input string req, input logic [7:0] b, input int d,
                             input logic ir, input logic stop_v, input int glitch_j,
                             input int jit, input logic echk, input logic exp_noise);
        int v0;
        v0 = vcount;
        send_frame(b, d, ir, stop_v, glitch_j, jit, echk);
        repeat (8) @(negedge clk);
        chk({req, " strobe count"}, vcount - v0, 1);
        chk({req, " data"}, cap_data, b);
        chk({req, " noise"}, cap_noise, exp_noise);
        chk({req, " framing"}, cap_frame, !stop_v);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        edge_clr = 1'b1;
        @(negedge clk);
        edge_clr = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog R3 actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd7));
        repeat (4) @(negedge clk);
        chk("R1 data in reset", rx_data, 0);
        chk("R1 flags in reset", {rx_valid, noise_err, frame_err, edge_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data after reset", rx_data, 0);
        chk("R1 flags after reset", {rx_valid, noise_err, frame_err, edge_flag}, 0);
        repeat (5) @(negedge clk);

        // Basic reception at several divisors, divisor 0 acts as 1
        run_frame("R3 normal div1", 8'h5A, 1, 1'b0, 1'b1, -1, 0, 1'b0, 1'b0);
        run_frame("R2 div0", 8'hC3, 0, 1'b0, 1'b1, -1, 0, 1'b0, 1'b0);
        run_frame("R2 div4", 8'h81, 4, 1'b0, 1'b1, -1, 0, 1'b0, 1'b0);

        // Noise: middle sample of data bit 2 inverted
        run_frame("R5 noisy bit", 8'h3C, 1, 1'b0, 1'b1, 3, 0, 1'b0, 1'b1);
        run_frame("R5 clean after noise", 8'h3C, 1, 1'b0, 1'b1, -1, 0, 1'b0, 1'b0);

        // Framing errors in both modes
        run_frame("R6 low stop normal", 8'hA7, 2, 1'b0, 1'b0, -1, 0, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        run_frame("R6 pulse in stop infrared", 8'h1E, 2, 1'b1, 1'b0, -1, 0, 1'b0, 1'b0);
        repeat (60) @(negedge clk);

        // Infrared pulses with per-bit edge flag checks
        clear_flag();
        run_frame("R8 infrared zeros", 8'h00, 2, 1'b1, 1'b1, -1, 1, 1'b1, 1'b0);
        clear_flag();
        run_frame("R8 infrared mixed", 8'hA5, 1, 1'b1, 1'b1, -1, 0, 1'b1, 1'b0);

        // Late boundaries
        run_frame("R11 all boundaries late", 8'h96, 2, 1'b0, 1'b1, -1, 1, 1'b0, 1'b0);
        run_frame("R11 infrared late pulses", 8'h69, 3, 1'b1, 1'b1, -1, 1, 1'b0, 1'b0);

        // Back to back frames, no gap
        begin
            int v0;
            v0 = vcount;
            send_frame(8'h11, 1, 1'b0, 1'b1, -1, 0, 1'b0);
            send_frame(8'hEE, 1, 1'b0, 1'b1, -1, 0, 1'b0);
            repeat (8) @(negedge clk);
            chk("R12 two strobes", vcount - v0, 2);
            chk("R12 second byte", cap_data, 8'hEE);
        end

        // Edge set and clear in the same cycle, then a lone clear
        baud_div = 16'd8;
        ir_mode  = 1'b0;
        repeat (200) @(negedge clk);
        clear_flag();
        chk("R10 flag cleared", edge_flag, 0);
        begin
            int v0;
            v0 = vcount;
            @(negedge clk);
            rxd_raw = 1'b0;
            @(negedge clk);
            rxd_raw = 1'b1;
            @(negedge clk);
            chk("R9 flag not yet set", edge_flag, 0);
            edge_clr = 1'b1;
            @(negedge clk);
            edge_clr = 1'b0;
            chk("R10 set wins over clear", edge_flag, 1);
            edge_clr = 1'b1;
            @(negedge clk);
            edge_clr = 1'b0;
            chk("R10 lone clear", edge_flag, 0);
            // Short low glitch at divisor 4
            baud_div = 16'd4;
            repeat (3) begin
                @(negedge clk);
                rxd_raw = 1'b0;
            end
            @(negedge clk);
            rxd_raw = 1'b1;
            repeat (400) @(negedge clk);
            chk("R7 glitches give no byte", vcount - v0, 0);
        end

        // Random frames, random divisor, mode, jitter and gaps
        for (int k = 0; k < 40; k++) begin
            logic [7:0] b;
            logic       ir;
            int         d;
            b  = 8'($urandom);
            ir = 1'($urandom);
            case ($urandom_range(3, 0))
                0:       d = 1;
                1:       d = 2;
                2:       d = 3;
                default: d = 5;
            endcase
            run_frame(ir ? "R8 random infrared" : "R3 random normal",
                      b, d, ir, 1'b1, -1, 2, 1'b0, 1'b0);
            repeat ($urandom_range(10, 0)) @(negedge clk);
        end

        summary();
    end

endmodule